// File: doc/BRIEF.md
# Root Hub Port Status Register Bank

This block holds the status and control word for each downstream port of a USB host controller root hub. It supports one to four ports. Each port word splits into two halves. The low half shows what the port is doing now: attached, enabled, suspended, over current, in reset, powered, and slow device. The high half keeps sticky change flags. Software clears a change flag by writing a one to it.

Software reaches the bank through plain single-cycle register writes and a combinational read mux. A write's low half is decoded as a set of port commands. These commands are held back while the bus reports a transaction in flight. Each port keeps one pending command slot, and that slot is released on the first idle cycle.

The bank times a port reset by counting millisecond tick pulses. It samples the connect, overcurrent and low-speed inputs of every port once per clock, and it raises change flags on transitions. Every interface here is plain control and status: there is no streaming data path, so there is no valid/ready handshake and no back-pressure.

Top module: `rh_port_bank`

## Requirements
- R1: After reset, every port word reads 0 and no port reset request is driven.
- R2: The word of port p is selected by `rd_port`. Its bit positions are: 0 attached, 1 enabled, 2 suspended, 3 over current, 4 in reset, 8 powered, 9 slow device. The change flags sit at 16 attach, 17 enable, 18 suspend, 19 over current, 20 reset done. A `rd_port` value of `NPORTS` or above reads 0, and a write to such a port has no effect.
- R3: Bits 31:21, 15:10 and 7:5 always read 0, and writing ones to them changes nothing.
- R4: The attached bit takes the value (powered AND `conn_in`) one clock later. Any change of that value sets bit 16. When the value becomes 0, the enabled, suspended and in-reset bits clear, and bit 17 is set if the port was enabled.
- R5: Bit 3 follows `oc_in` one clock later. Every change of it sets bit 19.
- R6: Writing a one to a command bit acts on the port:
  - bit 8 powers the port on, and bit 9 powers it off (off wins).
  - bit 1 enables the port if it is attached, and bit 0 disables it (disable wins).
  - bit 2 suspends the port if it is enabled.
  - bit 3 resumes a suspended port, clearing bit 2 and setting bit 18.
- R7: Writing a one to bit 4 on an attached port that is not already in reset sets the in-reset bit and `port_rst_req`, and clears the suspended bit. On the clock that samples the tenth `ms_tick` pulse after that, the in-reset bit clears, the enabled bit sets, and bit 20 sets. An unattached port ignores the command.
- R8: Writing a one to any of bits 20:16 clears that flag on the next clock, and writing a zero leaves it unchanged. A hardware set in the same clock wins over the clear.
- R9: Command bits written while `txn_busy` is high take effect only on the first clock at which `txn_busy` is low. Flag clears in bits 20:16 take effect at once, even while the bus is busy.
- R10: Each port holds one pending command. A later write with any command bit set replaces it. A write that carries no command bits does not disturb it.
- R11: Bit 9 equals (attached-input AND powered AND `lowspd_in`), sampled one clock earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Single-cycle register write strobe |
| wr_port | input | SEL_W | Port index of the write |
| wr_data | input | 32 | Write data: commands in the low half, flag clears in the high half |
| rd_port | input | SEL_W | Port index of the read |
| rd_data | output | 32 | Port word of `rd_port` (combinational) |
| txn_busy | input | 1 | High while a bus transaction is in flight |
| ms_tick | input | 1 | One-clock pulse every millisecond |
| conn_in | input | NPORTS | Per-port device present |
| oc_in | input | NPORTS | Per-port overcurrent report |
| lowspd_in | input | NPORTS | Per-port slow device indication |
| port_rst_req | output | NPORTS | Per-port reset signalling request |

## Verification
A stuck or misordered pending slot shows up at the read port within one clock after `txn_busy` falls: the wrong command lands, or a replaced one lands. A reset counter that is off by one is exposed exactly at the tenth tick. At that point `port_rst_req` and the in-reset bit stay high for one tick too long or fall one tick early. A lost transition on a sampled input leaves a change flag clear on the very next read, and a mis-ordered clear and set hides a flag in the same cycle. Every port word and the reset request vector are compared with a bench model on every clock, so any diverging register is reported in the cycle it first differs.

// File: rtl/rhp_pkg.sv
package rhp_pkg;
  localparam int CHG_W = 5;
  localparam int STAT_W = 16;

  typedef struct packed {
    logic pwr_on;
    logic pwr_off;
    logic rst;
    logic susp;
    logic resume;
    logic en;
    logic dis;
  } port_cmd_t;

  function automatic port_cmd_t decode_cmd(input logic [31:0] d);
    port_cmd_t c;
    c.dis     = d[0];
    c.en      = d[1];
    c.susp    = d[2];
    c.resume  = d[3];
    c.rst     = d[4];
    c.pwr_on  = d[8];
    c.pwr_off = d[9];
    return c;
  endfunction
endpackage

// File: rtl/rhp_cmd_hold.sv
module rhp_cmd_hold
  import rhp_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      wr_hit_i,
  input  port_cmd_t wr_cmd_i,
  input  logic      busy_i,
  output logic      apply_o,
  output port_cmd_t cmd_o
);
  logic      pend_q;
  port_cmd_t pcmd_q;

  always_comb begin
    apply_o = 1'b0;
    cmd_o   = pcmd_q;
    if (wr_hit_i && !busy_i) begin
      apply_o = 1'b1;
      cmd_o   = wr_cmd_i;
    end else if (!wr_hit_i && !busy_i && pend_q) begin
      apply_o = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      pcmd_q <= '0;
    end else if (wr_hit_i) begin
      if (busy_i) begin
        pend_q <= 1'b1;
        pcmd_q <= wr_cmd_i;
      end else begin
        pend_q <= 1'b0;
      end
    end else if (!busy_i) begin
      pend_q <= 1'b0;
    end
  end
endmodule

// File: rtl/rhp_port_core.sv
module rhp_port_core
  import rhp_pkg::*;
#(
  parameter int RST_TICKS = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              conn_i,
  input  logic              oc_i,
  input  logic              lowspd_i,
  input  logic              ms_tick_i,
  input  logic              apply_i,
  input  port_cmd_t         cmd_i,
  input  logic [CHG_W-1:0]  clr_i,
  output logic [STAT_W-1:0] stat_o,
  output logic [CHG_W-1:0]  chg_o,
  output logic              rst_req_o
);
  localparam int CNT_W = $clog2(RST_TICKS + 1);
  localparam logic [CNT_W-1:0] LAST_TICK = CNT_W'(RST_TICKS - 1);

  logic ccs_q, pes_q, pss_q, poci_q, prs_q, pps_q, lsda_q;
  logic [CHG_W-1:0] chg_q;
  logic [CNT_W-1:0] cnt_q;
  logic live;

  assign live = pps_q & conn_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ccs_q  <= 1'b0;
      pes_q  <= 1'b0;
      pss_q  <= 1'b0;
      poci_q <= 1'b0;
      prs_q  <= 1'b0;
      pps_q  <= 1'b0;
      lsda_q <= 1'b0;
      chg_q  <= '0;
      cnt_q  <= '0;
    end else begin
      // clears first, hardware sets below override them
      chg_q <= chg_q & ~clr_i;
      ccs_q <= live;
      if (live != ccs_q) chg_q[0] <= 1'b1;
      poci_q <= oc_i;
      if (oc_i != poci_q) chg_q[3] <= 1'b1;
      lsda_q <= live & lowspd_i;
      if (!live) begin
        if (pes_q) chg_q[1] <= 1'b1;
        pes_q <= 1'b0;
        pss_q <= 1'b0;
        prs_q <= 1'b0;
        cnt_q <= '0;
      end else begin
        if (prs_q && ms_tick_i) begin
          if (cnt_q == LAST_TICK) begin
            prs_q    <= 1'b0;
            pes_q    <= 1'b1;
            chg_q[4] <= 1'b1;
            cnt_q    <= '0;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        if (apply_i) begin
          if (cmd_i.en && ccs_q) pes_q <= 1'b1;
          if (cmd_i.dis) pes_q <= 1'b0;
          if (cmd_i.susp && pes_q) pss_q <= 1'b1;
          if (cmd_i.resume && pss_q) begin
            pss_q    <= 1'b0;
            chg_q[2] <= 1'b1;
          end
          if (cmd_i.rst && ccs_q && !prs_q) begin
            prs_q <= 1'b1;
            cnt_q <= '0;
            pss_q <= 1'b0;
          end
        end
      end
      if (apply_i) begin
        if (cmd_i.pwr_on) pps_q <= 1'b1;
        if (cmd_i.pwr_off) pps_q <= 1'b0;
      end
    end
  end

  assign stat_o    = {6'b0, lsda_q, pps_q, 3'b0, prs_q, poci_q, pss_q, pes_q, ccs_q};
  assign chg_o     = chg_q;
  assign rst_req_o = prs_q;
endmodule

// File: rtl/rh_port_bank.sv
module rh_port_bank
  import rhp_pkg::*;
#(
  parameter int NPORTS    = 4,
  parameter int SEL_W     = 3,
  parameter int RST_TICKS = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [SEL_W-1:0]  wr_port,
  input  logic [31:0]       wr_data,
  input  logic [SEL_W-1:0]  rd_port,
  output logic [31:0]       rd_data,
  input  logic              txn_busy,
  input  logic              ms_tick,
  input  logic [NPORTS-1:0] conn_in,
  input  logic [NPORTS-1:0] oc_in,
  input  logic [NPORTS-1:0] lowspd_in,
  output logic [NPORTS-1:0] port_rst_req
);
  localparam int PAD_W = 32 - CHG_W - STAT_W;

  logic [STAT_W-1:0]        stat_w [NPORTS];
  logic [CHG_W-1:0]         chg_w  [NPORTS];
  logic [NPORTS*STAT_W-1:0] stat_flat;
  logic [NPORTS*CHG_W-1:0]  chg_flat;
  port_cmd_t                wr_cmd;
  logic                     unused_wr;

  assign wr_cmd    = decode_cmd(wr_data);
  assign unused_wr = ^{wr_data[31:21], wr_data[15:10], wr_data[7:5]};

  for (genvar i = 0; i < NPORTS; i++) begin : g_port
    logic             sel, hit, apply;
    port_cmd_t        cmd;
    logic [CHG_W-1:0] clr;

    assign sel = wr_en && (wr_port == SEL_W'(i));
    assign hit = sel && (|wr_cmd);
    assign clr = sel ? wr_data[16 +: CHG_W] : '0;

    rhp_cmd_hold u_hold (
      .clk(clk), .rst_n(rst_n), .wr_hit_i(hit), .wr_cmd_i(wr_cmd),
      .busy_i(txn_busy), .apply_o(apply), .cmd_o(cmd)
    );

    rhp_port_core #(.RST_TICKS(RST_TICKS)) u_core (
      .clk(clk), .rst_n(rst_n), .conn_i(conn_in[i]), .oc_i(oc_in[i]),
      .lowspd_i(lowspd_in[i]), .ms_tick_i(ms_tick), .apply_i(apply),
      .cmd_i(cmd), .clr_i(clr), .stat_o(stat_w[i]), .chg_o(chg_w[i]),
      .rst_req_o(port_rst_req[i])
    );

    assign stat_flat[i*STAT_W +: STAT_W] = stat_w[i];
    assign chg_flat[i*CHG_W +: CHG_W]    = chg_w[i];
  end

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < NPORTS; i++) begin
      if (rd_port == SEL_W'(i)) rd_data = {{PAD_W{1'b0}}, chg_w[i], stat_w[i]};
    end
  end
endmodule

// File: rtl/rhp_bank_chk.sv
module rhp_bank_chk #(
  parameter int NPORTS = 4
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 txn_busy,
  input logic [31:0]          rd_data,
  input logic [NPORTS*16-1:0] stat_flat,
  input logic [NPORTS*5-1:0]  chg_flat
);
  // R3
  rsvd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data[31:21] == '0) && (rd_data[15:10] == '0) && (rd_data[7:5] == '0));

  for (genvar i = 0; i < NPORTS; i++) begin : g_chk
    // R9
    pwr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      txn_busy |=> $stable(stat_flat[i*16+8]));
    // R7
    rst_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(chg_flat[i*5+4]) |-> $fell(stat_flat[i*16+4]));
    // R7
    rst_attached_chk: assert property (@(posedge clk) disable iff (!rst_n)
      stat_flat[i*16+4] |-> stat_flat[i*16+0]);
    // R6
    en_attached_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(stat_flat[i*16+1]) |-> stat_flat[i*16+0]);
    // R5
    oc_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(chg_flat[i*5+3]) |-> !$stable(stat_flat[i*16+3]));
    // R4
    conn_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(chg_flat[i*5+0]) |-> !$stable(stat_flat[i*16+0]));
  end
endmodule

bind rh_port_bank rhp_bank_chk #(.NPORTS(NPORTS)) u_chk (
  .clk(clk), .rst_n(rst_n), .txn_busy(txn_busy), .rd_data(rd_data),
  .stat_flat(stat_flat), .chg_flat(chg_flat)
);

// File: tb/sim_rh_port_bank.sv
module sim_rh_port_bank;
  localparam int CLK_P = 20;
  localparam int NP = 4;
  localparam int RT = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [2:0] wr_port = '0;
  logic [31:0] wr_data = '0;
  logic [2:0] rd_port = '0;
  logic [31:0] rd_data;
  logic txn_busy = 1'b0;
  logic ms_tick = 1'b0;
  logic [NP-1:0] conn = '0, oc = '0, lows = '0;
  logic [NP-1:0] port_rst_req;

  int checks = 0;
  int errors = 0;
  int cyc_n = 0;

  always #(CLK_P/2) clk = ~clk;

  rh_port_bank #(.NPORTS(NP), .SEL_W(3), .RST_TICKS(RT)) u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_port(wr_port), .wr_data(wr_data),
    .rd_port(rd_port), .rd_data(rd_data), .txn_busy(txn_busy), .ms_tick(ms_tick),
    .conn_in(conn), .oc_in(oc), .lowspd_in(lows), .port_rst_req(port_rst_req)
  );

  // bench model
  bit m_ccs[NP], m_pes[NP], m_pss[NP], m_poci[NP], m_prs[NP], m_pps[NP], m_lsda[NP];
  bit [4:0] m_chg[NP];
  int m_cnt[NP];
  bit m_pend[NP];
  bit [9:0] m_pc[NP];

  function automatic logic [31:0] m_word(int p);
    return {11'b0, m_chg[p], 6'b0, m_lsda[p], m_pps[p], 3'b0,
            m_prs[p], m_poci[p], m_pss[p], m_pes[p], m_ccs[p]};
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int p = 0; p < NP; p++) begin
        m_ccs[p] = 0; m_pes[p] = 0; m_pss[p] = 0; m_poci[p] = 0; m_prs[p] = 0;
        m_pps[p] = 0; m_lsda[p] = 0; m_chg[p] = 0; m_cnt[p] = 0; m_pend[p] = 0; m_pc[p] = 0;
      end
    end else begin
      for (int p = 0; p < NP; p++) begin
        bit whit, nz, apply, live;
        bit o_ccs, o_pes, o_pss, o_poci, o_prs, o_pps;
        bit [9:0] cmd, ac;
        int o_cnt;
        whit = wr_en && (wr_port == 3'(p));
        cmd = wr_data[9:0] & 10'h31F;
        nz = |cmd;
        apply = 0; ac = 0;
        if (whit && nz && !txn_busy) begin apply = 1; ac = cmd; m_pend[p] = 0; end
        else if (whit && nz) begin m_pend[p] = 1; m_pc[p] = cmd; end
        else if (!txn_busy && m_pend[p]) begin apply = 1; ac = m_pc[p]; m_pend[p] = 0; end
        o_ccs = m_ccs[p]; o_pes = m_pes[p]; o_pss = m_pss[p]; o_poci = m_poci[p];
        o_prs = m_prs[p]; o_pps = m_pps[p]; o_cnt = m_cnt[p];
        live = o_pps & conn[p];
        if (whit) m_chg[p] = m_chg[p] & ~wr_data[20:16];
        m_ccs[p] = live;
        if (live != o_ccs) m_chg[p][0] = 1;
        m_poci[p] = oc[p];
        if (oc[p] != o_poci) m_chg[p][3] = 1;
        m_lsda[p] = live & lows[p];
        if (!live) begin
          if (o_pes) m_chg[p][1] = 1;
          m_pes[p] = 0; m_pss[p] = 0; m_prs[p] = 0; m_cnt[p] = 0;
        end else begin
          if (o_prs && ms_tick) begin
            if (o_cnt == RT - 1) begin
              m_prs[p] = 0; m_pes[p] = 1; m_chg[p][4] = 1; m_cnt[p] = 0;
            end else m_cnt[p] = o_cnt + 1;
          end
          if (apply) begin
            if (ac[1] && o_ccs) m_pes[p] = 1;
            if (ac[0]) m_pes[p] = 0;
            if (ac[2] && o_pes) m_pss[p] = 1;
            if (ac[3] && o_pss) begin m_pss[p] = 0; m_chg[p][2] = 1; end
            if (ac[4] && o_ccs && !o_prs) begin m_prs[p] = 1; m_cnt[p] = 0; m_pss[p] = 0; end
          end
        end
        if (apply) begin
          if (ac[8]) m_pps[p] = 1;
          if (ac[9]) m_pps[p] = 0;
        end
      end
    end
  end

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic expect_word(input int p, input logic [31:0] exp, input string tag);
    rd_port = 3'(p);
    #1;
    check(rd_data, exp, tag);
  endtask

  task automatic compare_all();
    logic [31:0] rq;
    for (int p = 0; p <= NP; p++) begin
      rd_port = 3'(p);
      #1;
      check(rd_data, (p < NP) ? m_word(p) : 32'h0, "R2 model word");
    end
    rq = '0;
    for (int p = 0; p < NP; p++) rq[p] = m_prs[p];
    check({28'b0, port_rst_req}, rq, "R7 model reset request");
  endtask

  task automatic cyc();
    @(negedge clk);
    compare_all();
  endtask

  task automatic wr(input int p, input logic [31:0] d);
    wr_en = 1'b1; wr_port = 3'(p); wr_data = d;
    cyc();
    wr_en = 1'b0;
  endtask

  always @(posedge clk) begin
    cyc_n++;
    if (cyc_n > 150000) begin
      errors++;
      $display("FAIL watchdog expired actual=%0d expected<150000", cyc_n);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    cyc();
    // R1 reset state
    for (int p = 0; p < NP; p++) expect_word(p, 32'h0, "R1 reset word");
    check({28'b0, port_rst_req}, 32'h0, "R1 reset request");

    // R6 power on, R4 attach, R11 slow device
    conn[0] = 1'b1; lows[0] = 1'b1;
    wr(0, 32'h0000_0100);
    expect_word(0, 32'h0000_0100, "R6 power on");
    cyc();
    expect_word(0, 32'h0001_0301, "R4 R11 attach");

    // R3 reserved, R8 write zero no effect
    wr(0, 32'hFFE0_FCE0);
    expect_word(0, 32'h0001_0301, "R3 R8 reserved ones");
    wr(0, 32'h0001_0000);
    expect_word(0, 32'h0000_0301, "R8 clear attach flag");

    // R7 timed reset
    wr(0, 32'h0000_0010);
    expect_word(0, 32'h0000_0311, "R7 reset start");
    check({31'b0, port_rst_req[0]}, 32'h1, "R7 request high");
    for (int k = 0; k < RT - 1; k++) begin
      ms_tick = 1'b1; cyc(); ms_tick = 1'b0; cyc();
    end
    expect_word(0, 32'h0000_0311, "R7 before last tick");
    ms_tick = 1'b1; cyc(); ms_tick = 1'b0;
    expect_word(0, 32'h0010_0303, "R7 reset done");
    check({31'b0, port_rst_req[0]}, 32'h0, "R7 request low");

    // R9 deferral, R10 replacement
    txn_busy = 1'b1;
    wr(0, 32'h0000_0004);
    cyc(); cyc();
    expect_word(0, 32'h0010_0303, "R9 suspend held");
    wr(0, 32'h0000_0001);
    expect_word(0, 32'h0010_0303, "R9 disable held");
    wr(0, 32'h0010_0000);
    expect_word(0, 32'h0000_0303, "R9 clear while busy");
    txn_busy = 1'b0;
    cyc();
    expect_word(0, 32'h0000_0301, "R10 newer command wins");

    // R6 enable, suspend, resume
    wr(0, 32'h0000_0002);
    expect_word(0, 32'h0000_0303, "R6 enable");
    wr(0, 32'h0000_0004);
    expect_word(0, 32'h0000_0307, "R6 suspend");
    wr(0, 32'h0000_0008);
    expect_word(0, 32'h0004_0303, "R6 resume");

    // R5 overcurrent
    oc[1] = 1'b1; cyc();
    expect_word(1, 32'h0008_0008, "R5 oc rise");
    oc[1] = 1'b0; cyc();
    expect_word(1, 32'h0008_0000, "R5 oc fall");

    // R7 reset on unattached port ignored
    wr(2, 32'h0000_0010);
    expect_word(2, 32'h0, "R7 unattached reset");
    check({31'b0, port_rst_req[2]}, 32'h0, "R7 unattached request");

    // R4 detach
    wr(0, 32'h001F_0000);
    conn[0] = 1'b0; cyc();
    expect_word(0, 32'h0003_0100, "R4 detach");

    // R2 invalid port
    wr(5, 32'h001F_0100);
    expect_word(5, 32'h0, "R2 invalid port");

    // random phase
    for (int n = 0; n < 4000; n++) begin
      logic [31:0] d;
      txn_busy = ($urandom % 10) < 4;
      ms_tick = ($urandom % 3) == 0;
      if ($urandom % 40 == 0) conn[$urandom % NP] ^= 1'b1;
      if ($urandom % 60 == 0) oc[$urandom % NP] ^= 1'b1;
      if ($urandom % 50 == 0) lows[$urandom % NP] ^= 1'b1;
      wr_en = ($urandom % 5) == 0;
      wr_port = 3'($urandom % 6);
      d = $urandom & 32'h001F_031F;
      if ($urandom % 4 != 0) d[9] = 1'b0;
      wr_data = d;
      cyc();
    end
    wr_en = 1'b0;

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule